// File: doc/BRIEF.md
# Dual-IO Serial Flash Command Target

This block is the command end of a serial flash device that listens on a two-wire data bus. The host holds an active-low select, and on every clock while select is low it places two bits on the bus: the odd (higher) bit of each pair on `dq1` and the even bit on `dq0`. The block rebuilds whole bytes from those pairs. The first byte is an instruction, the next three are a 24-bit address with the most significant byte first, and any further bytes are data. Nothing is carried out while the bytes arrive. The instruction runs on the first clock at which select is seen high again, and only if the select rose on a byte boundary.

Three instructions are decoded. The first sets a write-enable latch. The second programs a 64-byte one-time-programmable (OTP) area, where bits can only go from 1 to 0. The third erases one subsector of the array to all-ones. Both program and erase need the latch to be set first, and the latch clears once either of them has been carried out. The array is scaled down to a few subsectors of a parameterised size, and the whole array is treated as the boot region. A 64-byte view port lets a bench read back either the OTP area or any single subsector of the array.

Top module: `flash_dio_target`

## Requirements
- R1: On reset `weLatch` is 0, every OTP byte is FFh, and array byte i holds (i mod 256) XOR A5h.
- R2: Each clock with `csN` low delivers one bit pair: `dq1` carries bit 7, 5, 3 or 1 and `dq0` carries bit 6, 4, 2 or 0, with the highest pair first. Four clocks make one byte. The byte order is instruction, address bits 23..16, address bits 15..8, address bits 7..0, then data bytes.
- R3: Instruction 06h, sent as exactly one whole byte, sets `weLatch` when select rises.
- R4: Instruction 42h followed by address a and data bytes d0..dn makes OTP byte a+k equal to its old value AND dk. Data for positions at or beyond 64 is dropped and does not wrap, and no OTP bit ever goes from 0 to 1.
- R5: Program (42h) and erase (20h) leave all memory unchanged when `weLatch` is 0.
- R6: A program (42h) with the address complete, or an erase (20h) with exactly three address bytes, that ends on a byte boundary with `weLatch` set clears `weLatch`.
- R7: Instruction 20h with exactly three address bytes sets all bytes of the subsector holding the address to FFh and leaves the other subsectors as they were. The same instruction with extra bytes is discarded.
- R8: An erase whose address lies beyond the scaled array (the boot region) changes no memory, but it still clears `weLatch`.
- R9: If select rises part-way through a byte, the whole instruction is discarded, including a write-enable.
- R10: An instruction byte other than 06h, 42h or 20h changes neither the memory nor `weLatch`.
- R11: Memory changes only on the clock that follows select being sampled high. `viewData` bits 8k+7..8k show OTP byte k when `viewOtp` is 1, and otherwise byte k of subsector `viewPage`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the bus pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; its rising edge ends an instruction |
| dq0 | input | 1 | Even bit of each bit pair |
| dq1 | input | 1 | Odd bit of each bit pair |
| viewOtp | input | 1 | 1 selects the OTP area on the view port |
| viewPage | input | $clog2(NUM_SUB) | Array subsector shown when viewOtp is 0 |
| weLatch | output | 1 | Write-enable latch |
| viewData | output | 8*SUB_BYTES | Byte view of the selected area, byte k in bits 8k+7..8k |

## Verification
Program bursts are started at the bottom, in the middle and near the top of the OTP area, and with start addresses past it. This separates correct pointer stepping from wrap-around and from an off-by-one at the 64-byte edge. Repeated programs of the same byte with patterns that overlap expose an overwrite where an AND is required. Erases are sent inside each subsector and beyond the array to check the subsector decode and the region limit. Every instruction is also sent with the latch clear, with an extra byte, and cut short mid-byte, which separates gating by the latch, by the byte count and by the boundary. The view windows are also compared while select is still low, so that any write made before select rises is caught.

// File: rtl/flash_dio_pkg.sv
package flash_dio_pkg;
  localparam logic [7:0] OP_WREN      = 8'h06;
  localparam logic [7:0] OP_OTP_PROG  = 8'h42;
  localparam logic [7:0] OP_SUB_ERASE = 8'h20;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clearBuf;     // instruction byte complete: reset program buffer
    logic shiftAddr;    // address byte complete
    logic dataByte;     // program data byte complete
    logic commitProg;   // apply buffer to OTP
    logic commitErase;  // erase addressed subsector
  } dpStrobes_t;
endpackage

// File: rtl/flash_dio_ctrl.sv
module flash_dio_ctrl
  import flash_dio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic [7:0] byteNow,
  output dpStrobes_t strb,
  output logic       wel
);
  localparam logic [2:0] IDX_DATA = 3'd4;  // first data byte position
  localparam logic [2:0] IDX_SAT  = 3'd5;  // saturates: at least one data byte seen

  logic [1:0] pairCnt;
  logic [2:0] byteIdx;
  logic [7:0] opcode;
  logic       csLowPrev;
  logic       byteDone, endEvt, onBoundary;
  logic       wrenOk, progOk, eraseOk;

  assign byteDone   = !csN && (pairCnt == 2'd3);
  assign endEvt     = csN && csLowPrev;
  assign onBoundary = (pairCnt == 2'd0);

  assign wrenOk  = endEvt && onBoundary && (byteIdx == 3'd1) && (opcode == OP_WREN);
  assign progOk  = endEvt && onBoundary && (byteIdx >= IDX_DATA) &&
                   (opcode == OP_OTP_PROG) && wel;
  assign eraseOk = endEvt && onBoundary && (byteIdx == IDX_DATA) &&
                   (opcode == OP_SUB_ERASE) && wel;

  always_comb begin
    strb             = '0;
    strb.clearBuf    = byteDone && (byteIdx == 3'd0);
    strb.shiftAddr   = byteDone && (byteIdx >= 3'd1) && (byteIdx < IDX_DATA);
    strb.dataByte    = byteDone && (byteIdx >= IDX_DATA) && (opcode == OP_OTP_PROG);
    strb.commitProg  = progOk;
    strb.commitErase = eraseOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairCnt   <= '0;
      byteIdx   <= '0;
      opcode    <= '0;
      csLowPrev <= 1'b0;
      wel       <= 1'b0;
    end else begin
      csLowPrev <= !csN;
      if (!csN) begin
        pairCnt <= pairCnt + 2'd1;
        if (byteDone) begin
          if (byteIdx != IDX_SAT) byteIdx <= byteIdx + 3'd1;
          if (byteIdx == 3'd0) opcode <= byteNow;
        end
      end else begin
        pairCnt <= '0;
        byteIdx <= '0;
      end
      if (wrenOk) wel <= 1'b1;
      else if (progOk || eraseOk) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_dio_datapath.sv
module flash_dio_datapath
  import flash_dio_pkg::*;
#(
  parameter int SUB_BYTES = 64,  // bytes per subsector, power of two; also OTP size
  parameter int NUM_SUB   = 4    // subsectors in the scaled array, power of two, >= 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       dq0,
  input  logic                       dq1,
  input  dpStrobes_t                 strb,
  output logic [7:0]                 byteNow,
  input  logic                       viewOtp,
  input  logic [$clog2(NUM_SUB)-1:0] viewPage,
  output logic [8*SUB_BYTES-1:0]     viewData
);
  localparam int SUB_AW      = $clog2(SUB_BYTES);
  localparam int ARRAY_BYTES = SUB_BYTES * NUM_SUB;
  localparam int ARR_AW      = $clog2(ARRAY_BYTES);
  localparam int OTP_BYTES   = SUB_BYTES;

  logic [5:0]  shiftReg;
  logic [23:0] addrReg;
  logic [24:0] otpPtr;
  logic [7:0]  otpMem  [OTP_BYTES];
  logic [7:0]  progBuf [OTP_BYTES];
  logic [7:0]  arrMem  [ARRAY_BYTES];
  logic                     inRange;
  logic [ARR_AW-SUB_AW-1:0] eraseSub;

  assign byteNow  = {shiftReg, dq1, dq0};
  assign inRange  = (addrReg[23:ARR_AW] == '0);
  assign eraseSub = addrReg[ARR_AW-1:SUB_AW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (!csN) shiftReg <= byteNow[5:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      otpPtr  <= '0;
      for (int i = 0; i < OTP_BYTES; i++) begin
        otpMem[i]  <= 8'hFF;
        progBuf[i] <= 8'hFF;
      end
      for (int i = 0; i < ARRAY_BYTES; i++) arrMem[i] <= 8'(i) ^ 8'hA5;
    end else begin
      if (strb.shiftAddr) begin
        addrReg <= {addrReg[15:0], byteNow};
        otpPtr  <= {1'b0, addrReg[15:0], byteNow};
      end
      if (strb.clearBuf)
        for (int i = 0; i < OTP_BYTES; i++) progBuf[i] <= 8'hFF;
      if (strb.dataByte) begin
        if (otpPtr < 25'(OTP_BYTES)) progBuf[otpPtr[SUB_AW-1:0]] <= byteNow;
        otpPtr <= otpPtr + 25'd1;
      end
      if (strb.commitProg)
        for (int i = 0; i < OTP_BYTES; i++) otpMem[i] <= otpMem[i] & progBuf[i];
      if (strb.commitErase && inRange)
        for (int i = 0; i < ARRAY_BYTES; i++)
          if ((i / SUB_BYTES) == int'(eraseSub)) arrMem[i] <= 8'hFF;
    end
  end

  for (genvar k = 0; k < SUB_BYTES; k++) begin : g_view
    localparam logic [SUB_AW-1:0] KIDX = SUB_AW'(k);
    assign viewData[8*k +: 8] = viewOtp ? otpMem[k] : arrMem[{viewPage, KIDX}];
  end
endmodule

// File: rtl/flash_dio_target.sv
module flash_dio_target
  import flash_dio_pkg::*;
#(
  parameter int SUB_BYTES = 64,
  parameter int NUM_SUB   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       dq0,
  input  logic                       dq1,
  input  logic                       viewOtp,
  input  logic [$clog2(NUM_SUB)-1:0] viewPage,
  output logic                       weLatch,
  output logic [8*SUB_BYTES-1:0]     viewData
);
  dpStrobes_t strb;
  logic [7:0] byteNow;

  flash_dio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .byteNow(byteNow),
    .strb(strb), .wel(weLatch)
  );

  flash_dio_datapath #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .dq0(dq0), .dq1(dq1),
    .strb(strb), .byteNow(byteNow),
    .viewOtp(viewOtp), .viewPage(viewPage), .viewData(viewData)
  );
endmodule

// File: rtl/flash_dio_checker.sv
module flash_dio_checker #(
  parameter int SUB_BYTES = 64,
  parameter int NUM_SUB   = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic                       viewOtp,
  input logic [$clog2(NUM_SUB)-1:0] viewPage,
  input logic                       weLatch,
  input logic [8*SUB_BYTES-1:0]     viewData
);
  // R3: the latch is only set on the clock where select is seen high
  p_wel_set_at_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weLatch) |-> $past(csN));

  // R6: outside reset the latch only clears when an instruction ends
  p_wel_clear_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weLatch) |-> $past(csN));

  // R11: no memory change unless select was high at the previous edge
  p_mem_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csN) && $stable(viewOtp) && $stable(viewPage)) |-> $stable(viewData));

  // R4: OTP bits never rise
  p_otp_clear_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (viewOtp && $past(viewOtp)) |-> ((viewData & ~$past(viewData)) == '0));

  // R5: any memory change requires the latch to have been set
  p_write_needs_wel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(viewData) && $stable(viewOtp) && $stable(viewPage)) |-> $past(weLatch));
endmodule

bind flash_dio_target flash_dio_checker #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_chk (.*);

// File: tb/flash_dio_target_bench.sv
module flash_dio_target_bench;
  localparam int SUB_BYTES = 64;
  localparam int NUM_SUB   = 4;
  localparam int ARR       = SUB_BYTES * NUM_SUB;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, dq0 = 1'b0, dq1 = 1'b0, viewOtp = 1'b0;
  logic [1:0] viewPage = 2'd0;
  logic weLatch;
  logic [8*SUB_BYTES-1:0] viewData;

  always #10 clk = ~clk;  // 50 MHz

  flash_dio_target #(.SUB_BYTES(SUB_BYTES), .NUM_SUB(NUM_SUB)) u_flash_dio_target (
    .clk(clk), .rstN(rstN), .csN(csN), .dq0(dq0), .dq1(dq1),
    .viewOtp(viewOtp), .viewPage(viewPage), .weLatch(weLatch), .viewData(viewData)
  );

  logic [7:0] expOtp [SUB_BYTES];
  logic [7:0] expArr [ARR];
  logic       expWel;
  logic [7:0] txBuf  [80];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic checkWel(input string req);
    checks++;
    if (weLatch !== expWel) begin
      fails++;
      $display("FAIL %s weLatch actual=%0b expected=%0b", req, weLatch, expWel);
    end
  endtask

  task automatic checkWin(input string req, input bit otp, input int page);
    logic [8*SUB_BYTES-1:0] exp;
    viewOtp  = otp;
    viewPage = page[1:0];
    #1;
    for (int k = 0; k < SUB_BYTES; k++)
      exp[8*k +: 8] = otp ? expOtp[k] : expArr[page*SUB_BYTES + k];
    checks++;
    if (viewData !== exp) begin
      fails++;
      $display("FAIL %s window otp=%0b page=%0d actual=%h expected=%h",
               req, otp, page, viewData, exp);
    end
  endtask

  task automatic checkAll(input string req);
    checkWel(req);
    checkWin(req, 1'b1, 0);
    for (int p = 0; p < NUM_SUB; p++) checkWin(req, 1'b0, p);
  endtask

  // expected effect of one finished transaction, from the requirements
  function automatic void applyModel(input int n, input int extra);
    logic [7:0] tmp [SUB_BYTES];
    int a;
    if (extra != 0 || n == 0) return;                       // R9
    a = (n >= 4) ? {txBuf[1], txBuf[2], txBuf[3]} : 0;
    if (txBuf[0] == 8'h06 && n == 1) expWel = 1'b1;         // R3
    else if (txBuf[0] == 8'h42 && n >= 4 && expWel) begin   // R4 R6
      for (int k = 0; k < SUB_BYTES; k++) tmp[k] = 8'hFF;
      for (int k = 0; k < n - 4; k++)
        if (a + k < SUB_BYTES) tmp[a + k] = txBuf[4 + k];
      for (int k = 0; k < SUB_BYTES; k++) expOtp[k] &= tmp[k];
      expWel = 1'b0;
    end else if (txBuf[0] == 8'h20 && n == 4 && expWel) begin // R7 R8
      if (a < ARR)
        for (int k = 0; k < SUB_BYTES; k++) expArr[(a / SUB_BYTES) * SUB_BYTES + k] = 8'hFF;
      expWel = 1'b0;
    end
  endfunction

  task automatic sendPair(input logic b1, input logic b0);
    @(negedge clk);
    csN = 1'b0;
    dq1 = b1;
    dq0 = b0;
  endtask

  task automatic doTxn(input int n, input int extra, input string req);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 4; j++) sendPair(txBuf[i][7-2*j], txBuf[i][6-2*j]);
    for (int p = 0; p < extra; p++) sendPair(1'($urandom), 1'($urandom));
    @(negedge clk);
    checkAll("R11");          // nothing applied while select is low
    csN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    applyModel(n, extra);
    checkAll(req);
  endtask

  task automatic setHdr(input logic [7:0] op, input int a);
    txBuf[0] = op;
    txBuf[1] = 8'(a >> 16);
    txBuf[2] = 8'(a >> 8);
    txBuf[3] = 8'(a);
  endtask

  task automatic wren();
    txBuf[0] = 8'h06;
    doTxn(1, 0, "R3");
  endtask

  initial begin
    int unsigned seedv = 32'd20240611;
    void'($urandom(seedv));
    for (int k = 0; k < SUB_BYTES; k++) expOtp[k] = 8'hFF;
    for (int k = 0; k < ARR; k++) expArr[k] = 8'(k) ^ 8'hA5;
    expWel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    wren();                                                   // R3
    setHdr(8'h42, 3); txBuf[4] = 8'h0F; txBuf[5] = 8'hF0; txBuf[6] = 8'h3C;
    doTxn(7, 0, "R2 R4 R6");
    setHdr(8'h42, 3); txBuf[4] = 8'h00;
    doTxn(5, 0, "R5");                                        // latch clear
    wren();
    setHdr(8'h42, 3); txBuf[4] = 8'hF3;
    doTxn(5, 0, "R4");                                        // AND with 0Fh
    wren();
    setHdr(8'h42, 62); for (int k = 0; k < 4; k++) txBuf[4+k] = 8'h81;
    doTxn(8, 0, "R4");                                        // no wrap
    wren();
    setHdr(8'h42, 64); txBuf[4] = 8'h00;
    doTxn(5, 0, "R4");                                        // beyond OTP
    wren();
    setHdr(8'h20, 8'h85);
    doTxn(4, 0, "R7");
    wren();
    setHdr(8'h20, 8'h45); txBuf[4] = 8'h00;
    doTxn(5, 0, "R7");                                        // extra byte
    setHdr(8'h20, 8'h45);
    doTxn(4, 0, "R6 R7");                                     // latch clear now
    wren();
    setHdr(8'h20, 32'h000100);
    doTxn(4, 0, "R8");
    txBuf[0] = 8'h06;
    doTxn(1, 2, "R9");                                        // cut mid-byte
    wren();
    setHdr(8'h42, 0); txBuf[4] = 8'h00;
    doTxn(5, 3, "R9");
    txBuf[0] = 8'h99;
    doTxn(1, 0, "R10");
    setHdr(8'h5A, 0);
    doTxn(4, 0, "R10");

    for (int it = 0; it < 250; it++) begin
      int kind  = $urandom_range(0, 5);
      int extra = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 3) : 0;
      if ($urandom_range(0, 2) != 0 && kind != 0) wren();
      case (kind)
        0: begin txBuf[0] = 8'h06; doTxn(1, extra, "R3 R9"); end
        1, 5: begin
          int len = $urandom_range(0, 8);
          setHdr(8'h42, $urandom_range(0, 70));
          for (int k = 0; k < len; k++) txBuf[4+k] = 8'($urandom);
          doTxn(4 + len, (kind == 5) ? $urandom_range(1, 3) : extra, "R2 R4 R5 R9");
        end
        2: begin setHdr(8'h20, $urandom_range(0, 32'h11F)); doTxn(4, extra, "R7 R8 R5"); end
        3: begin
          logic [7:0] op = 8'($urandom);
          if (op == 8'h06 || op == 8'h42 || op == 8'h20) op = 8'hC3;
          setHdr(op, $urandom_range(0, 255));
          doTxn($urandom_range(1, 5), extra, "R10");
        end
        default: begin setHdr(8'h20, $urandom_range(0, 255)); txBuf[4] = 8'($urandom); doTxn(5, extra, "R7"); end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule